// File: doc/BRIEF.md
# Write-Once Timing Divider for Nonvolatile Memory Control

This block sits on the bus next to a nonvolatile memory controller. It holds one 8-bit configuration register that can be written only once after reset. It turns the bus clock into a slow, regular timing tick that the erase and program sequencer counts. Software writes the register once at start-up. That first write fixes the prescale choice and the divisor, and it also raises a sticky loaded flag. The flag is the only thing that lets erase and program operations go ahead. Every later write is dropped without effect.

The tick is a single-cycle enable in the bus clock domain, so no second clock domain exists. The tick period is the bus clock period times the prescale factor (1 or 8) times the divisor field plus one. Both counting stages stay cleared until the flag is set. They start counting on the cycle after the accepted write.

Top module: `clkdiv_wo`

## Requirements
- R1: After reset the register reads 0x00, `pe_enable` is 0 and `tick` is 0.
- R2: With `rd_en` high, `rdata` shows the register: bit 7 is the loaded flag, bit 6 is the prescale select, and bits 5..0 are the divisor. With `rd_en` low, `rdata` is 0x00.
- R3: The first write after reset stores `wdata[6:0]` into bits 6..0. It also sets the loaded flag, whatever the data is (0x00 included). The value of `wdata[7]` has no effect on bit 7.
- R4: Once the loaded flag is 1, writes change no register bit and do not alter the tick timing.
- R5: `pe_enable` is 0 while the loaded flag is 0 and 1 once it is set, and it stays 1 until reset.
- R6: With prescale select 0 and divisor D, `tick` repeats every D+1 bus cycles. With D = 0, it is high on every cycle.
- R7: With prescale select 1 and divisor D, `tick` repeats every 8×(D+1) bus cycles.
- R8: Counting starts from zero on the first cycle after the accepted write. The first tick falls on cycle P×(D+1)−1 of that count, where P is the prescale factor. Each tick is one bus cycle wide, except when P×(D+1) = 1.
- R9: A read in the same cycle as the accepted write returns the old value. The new value is readable from the next cycle.
- R10: No tick is produced while the loaded flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (0 when not reading) |
| tick | output | 1 | One-cycle timing pulse per divided period |
| pe_enable | output | 1 | Erase/program permission, equals loaded flag |

## Verification
The bench builds the block with its default widths: a 6-bit divisor and a divide-by-8 prescaler. Periods from 1 bus cycle up to the longest, 8×64 = 512 cycles, therefore fit within a short run. This reaches both prescale settings, the divisor extremes 0 and 63, and the pass-through case where the tick stays high. Each scenario starts from a fresh reset, so the write-once lock can be checked against a new first write every time.

// File: rtl/clkdiv_pkg.sv
// Shared widths and the register layout of the write-once timing divider.
// Assumes an 8-bit register: flag, prescale select, divisor.
package clkdiv_pkg;
    localparam int DIV_W    = 6;             // divisor field width
    localparam int PRE_LOG2 = 3;             // prescale factor = 2**PRE_LOG2
    localparam int REG_W    = DIV_W + 2;     // flag + prescale + divisor

    typedef struct packed {
        logic             loaded;
        logic             pre_sel;
        logic [DIV_W-1:0] div;
    } cfg_t;
endpackage

// File: rtl/wo_cfg_reg.sv
// Write-once configuration register. The first write after reset captures
// the low bits and sets the sticky loaded flag. Later writes are ignored.
// Assumes the strobes are synchronous to clk.
module wo_cfg_reg
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output cfg_t             cfg_q
);
    logic unused_wbit;
    assign unused_wbit = wdata[REG_W-1];

    // Capture the first write, then hold the value until reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en && !cfg_q.loaded) begin
            cfg_q.loaded  <= 1'b1;
            cfg_q.pre_sel <= wdata[DIV_W];
            cfg_q.div     <= wdata[DIV_W-1:0];
        end
    end
endmodule

// File: rtl/pre_stage.sv
// Optional fixed power-of-two prescaler. It emits a stage enable once every
// 2**PRE_LOG2 cycles when selected, or every cycle when not. It is held
// cleared while run is low.
module pre_stage #(
    parameter int PRE_LOG2 = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel,
    output logic stage_en
);
    generate
        if (PRE_LOG2 == 0) begin : g_none
            // Prescale factor of 1: every running cycle is a stage cycle
            always_comb stage_en = run;
        end else begin : g_cnt
            localparam logic [PRE_LOG2-1:0] LAST = '1;
            logic [PRE_LOG2-1:0] pcnt;

            // Free-running prescale counter, cleared until configured
            always_ff @(posedge clk) begin
                if (!rst_n || !run || !sel) pcnt <= '0;
                else                        pcnt <= pcnt + 1'b1;
            end

            // Stage enable on the last count, or always if bypassed
            always_comb stage_en = run && (!sel || (pcnt == LAST));
        end
    endgenerate
endmodule

// File: rtl/div_stage.sv
// Programmable divide-by-(div+1) stage counting prescaler enables. tick is
// high for the stage cycle that ends each period. Assumes div is stable
// while run is high.
module div_stage #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             stage_en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] dcnt;
    logic             at_end;

    // End-of-period compare
    always_comb at_end = (dcnt == div);

    // Divisor counter, wraps after reaching the programmed value
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  dcnt <= '0;
        else if (stage_en)   dcnt <= at_end ? '0 : dcnt + 1'b1;
    end

    // Tick output, single stage cycle at period end
    always_comb tick = run && stage_en && at_end;
endmodule

// File: rtl/clkdiv_wo.sv
// Top of the write-once timing divider: the configuration register, the
// prescaler and the divisor stage. Reads are combinational from the
// register, so a read in a write cycle returns the old contents.
module clkdiv_wo
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             tick,
    output logic             pe_enable
);
    cfg_t             cfg_q;
    logic             stage_en;
    logic             cfg_pre;
    logic [DIV_W-1:0] cfg_div;

    wo_cfg_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .wdata (wdata),
        .cfg_q (cfg_q)
    );

    // Break out the fields for the stages and the checker
    always_comb begin
        cfg_pre = cfg_q.pre_sel;
        cfg_div = cfg_q.div;
    end

    pre_stage #(.PRE_LOG2(PRE_LOG2)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (cfg_q.loaded),
        .sel      (cfg_pre),
        .stage_en (stage_en)
    );

    div_stage #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (cfg_q.loaded),
        .stage_en (stage_en),
        .div      (cfg_div),
        .tick     (tick)
    );

    // Read mux and permission output
    always_comb begin
        rdata     = rd_en ? cfg_q : '0;
        pe_enable = cfg_q.loaded;
    end
endmodule

// File: rtl/clkdiv_wo_chk.sv
// Property checker for clkdiv_wo, attached by bind.
module clkdiv_wo_chk
    import clkdiv_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             pe_enable,
    input logic             tick,
    input logic             cfg_pre,
    input logic [DIV_W-1:0] cfg_div
);
    // R5
    pe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pe_enable |=> pe_enable);
    // R3
    first_write_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pe_enable && wr_en) |=> pe_enable);
    // R5
    no_write_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pe_enable && !wr_en) |=> !pe_enable);
    // R4
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pe_enable |=> ($stable(cfg_pre) && $stable(cfg_div)));
    // R10
    no_tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pe_enable |-> !tick);
    // R7
    prescale_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cfg_pre) |=> !tick);
endmodule

bind clkdiv_wo clkdiv_wo_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .pe_enable (pe_enable),
    .tick      (tick),
    .cfg_pre   (cfg_pre),
    .cfg_div   (cfg_div)
);

// File: tb/clkdiv_wo_bench.sv
module clkdiv_wo_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       tick;
    logic       pe_enable;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    clkdiv_wo u_clkdiv_wo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .tick(tick), .pe_enable(pe_enable)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Write at a negedge, leave the bench at the negedge after the write edge
    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        rd_en = 1'b1; #1; v = rdata; rd_en = 1'b0;
    endtask

    // Sample tick for n cycles starting right after the accepted write
    task automatic measure(input string req, input int period, input int n);
        int bad = 0;
        int first_bad = -1;
        for (int i = 0; i < n; i++) begin
            logic exp_t;
            exp_t = ((i + 1) % period) == 0;
            if (tick !== exp_t) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
            @(negedge clk);
        end
        if (bad != 0) $display("FAIL %s period %0d mismatches %0d first at cycle %0d", req, period, bad, first_bad);
        check(req, bad[15:0], 16'd0);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        int seen = 0;
        do_reset();
        rd(v);
        check("R1 reset value", {8'h0, v}, 16'h0000);
        check("R1 pe_enable low", {15'h0, pe_enable}, 16'h0);
        for (int i = 0; i < 20; i++) begin
            if (tick) seen++;
            @(negedge clk);
        end
        check("R10 no tick before load", seen[15:0], 16'd0);
        check("R5 pe still low", {15'h0, pe_enable}, 16'h0);
        check("R2 rdata zero without rd_en", {8'h0, rdata}, 16'h0);
    endtask

    task automatic t_same_cycle_read();
        logic [7:0] v;
        do_reset();
        @(negedge clk);
        wr_en = 1'b1; wdata = 8'h45; rd_en = 1'b1; #1;
        check("R9 read during write old value", {8'h0, rdata}, 16'h0000);
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; #1;
        check("R9 new value next cycle", {8'h0, rdata}, 16'h00C5);
        rd_en = 1'b0;
        check("R5 pe high after write", {15'h0, pe_enable}, 16'h1);
        wr(8'h3A);
        rd(v);
        check("R4 second write ignored", {8'h0, v}, 16'h00C5);
        check("R5 pe stays high", {15'h0, pe_enable}, 16'h1);
    endtask

    task automatic t_zero_write();
        logic [7:0] v;
        do_reset();
        @(negedge clk);
        wr(8'h00);
        rd(v);
        check("R3 zero data still loads", {8'h0, v}, 16'h0080);
        measure("R6 div0 pass-through", 1, 16);
    endtask

    task automatic t_bit7_write();
        logic [7:0] v;
        do_reset();
        @(negedge clk);
        wr(8'h85);
        rd(v);
        check("R3 bit7 data ignored", {8'h0, v}, 16'h0085);
        check("R2 field layout div", {10'h0, v[5:0]}, 16'h0005);
        measure("R6 R8 div5 period", 6, 40);
    endtask

    task automatic t_prescale(input logic [5:0] d, input int ncyc);
        logic [7:0] v;
        do_reset();
        @(negedge clk);
        wr({2'b01, d});
        rd(v);
        check("R2 prescale bit readback", {15'h0, v[6]}, 16'h1);
        measure("R7 R8 prescaled period", 8 * (d + 1), ncyc);
    endtask

    task automatic t_lock_timing();
        do_reset();
        @(negedge clk);
        wr(8'h02);
        measure("R6 div2 period", 3, 9);
        wr(8'h40);
        // write edge counted as cycle 9; continue from cycle 10 of the period
        begin
            int bad = 0;
            for (int i = 10; i < 40; i++) begin
                if (tick !== (((i + 1) % 3) == 0)) bad++;
                @(negedge clk);
            end
            check("R4 late write leaves timing", bad[15:0], 16'd0);
        end
    endtask

    initial begin
        t_reset();
        t_same_cycle_read();
        t_zero_write();
        t_bit7_write();
        t_prescale(6'd0, 40);
        t_prescale(6'd3, 100);
        t_prescale(6'd63, 1100);
        t_lock_timing();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule